// File: doc/BRIEF.md
# Read-Sequence Mode Unlock Detector

This block watches the halfword read traffic of a cartridge bus and picks out one fixed chain of eleven read addresses. The chain switches an adapter between two operating modes. Ten positions in the chain must hit fixed addresses. The eighth read carries the selection: one address asks for media (I/O) mode, and another asks for RAM mode with writes allowed. Only the address of each read matters. The data returned by those reads, and every write on the bus, play no part in the chain.

The detector keeps a step counter and the selection seen at the eighth read. The mode registers load only when the eleventh read of a correct chain is accepted, so the outputs keep their old value while a chain is in progress. A read at a wrong address drops the chain. That read still counts as the first step if it hits the chain's opening address. Out of reset the adapter is in RAM mode with writes blocked.

Top module: `rdseq_unlock`

## Requirements
- R1: After reset, mode_media is 0 and ram_wr_en is 0.
- R2: A complete chain whose eighth read is at 0x08800006 sets mode_media to 1 and ram_wr_en to 0. The chain order is 0x08E00002, 0x0800000E, 0x08801FFC, 0x0800104A, 0x08800612, 0x08000000, 0x08801B66, then the selector read, then 0x0800080E, 0x08000000, 0x09000000.
- R3: A complete chain whose eighth read is at 0x0880000C sets mode_media to 0 and ram_wr_en to 1.
- R4: Both outputs hold their previous values until the rising edge that accepts the eleventh read. They change at that edge.
- R5: A read whose address does not match the expected step returns the chain to its start. If that read hits 0x08E00002, it counts as the first step.
- R6: At the eighth step, a read at any address other than the two selector codes aborts the chain.
- R7: Writes (acc_write=1) neither advance the chain nor reset it.
- R8: Cycles with acc_valid low neither advance the chain nor reset it.
- R9: Every completed chain replaces the previous mode, so the mode can be switched back and forth any number of times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | A bus access is present this cycle |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | ADDR_W | Byte address of the access |
| mode_media | output | 1 | 1 = media/I/O mode, 0 = RAM mode |
| ram_wr_en | output | 1 | 1 = writes to the RAM window are allowed |

## Verification
The chain state and both outputs are registered. The effect of an access therefore appears right after the rising edge that samples it, one cycle after the bench drives it. The bench drives each access on a falling edge and compares both outputs on the next falling edge. At that point its reference model has just taken in the same access. Idle cycles and interleaved writes are checked in the same way, one cycle after they occur. A chain that was wrongly advanced or wrongly reset therefore shows up as a mode value that differs from the model at the end of a later chain.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

   localparam int CHAIN_LEN = 11;
   localparam int SEL_STEP  = 7;

   localparam logic [31:0] CODE_MEDIA = 32'h0880_0006;
   localparam logic [31:0] CODE_RAM   = 32'h0880_000C;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_MEDIA = 2'd1,
      SEL_RAM   = 2'd2
   } sel_e;

   // Fixed address expected at each chain step (selector step returns 0).
   function automatic logic [31:0] chain_addr(input int idx);
      logic [31:0] a;
      case (idx)
         0:       a = 32'h08E0_0002;
         1:       a = 32'h0800_000E;
         2:       a = 32'h0880_1FFC;
         3:       a = 32'h0800_104A;
         4:       a = 32'h0880_0612;
         5:       a = 32'h0800_0000;
         6:       a = 32'h0880_1B66;
         8:       a = 32'h0800_080E;
         9:       a = 32'h0800_0000;
         10:      a = 32'h0900_0000;
         default: a = 32'h0000_0000;
      endcase
      return a;
   endfunction

endpackage

// File: rtl/rdseq_match.sv
module rdseq_match
   import rdseq_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int SEQ_LEN  = 11,
   parameter int SEL_POS  = 7
) (
   input  logic [ADDR_W-1:0]  addr_i,
   output logic [SEQ_LEN-1:0] hit_o,
   output sel_e               sel_o
);

   logic is_media;
   logic is_ram;

   assign is_media = (addr_i == ADDR_W'(CODE_MEDIA));
   assign is_ram   = (addr_i == ADDR_W'(CODE_RAM));

   always_comb begin
      if (is_media)    sel_o = SEL_MEDIA;
      else if (is_ram) sel_o = SEL_RAM;
      else             sel_o = SEL_NONE;
   end

   for (genvar i = 0; i < SEQ_LEN; i++) begin : g_step
      if (i == SEL_POS) begin : g_sel
         assign hit_o[i] = is_media | is_ram;
      end else begin : g_fixed
         assign hit_o[i] = (addr_i == ADDR_W'(chain_addr(i)));
      end
   end

   // R2/R3: the two selector codes never match together
   always_comb begin
      a_r2_codes_distinct: assert (!(is_media && is_ram));
   end

endmodule

// File: rtl/rdseq_tracker.sv
module rdseq_tracker
   import rdseq_pkg::*;
#(
   parameter int SEQ_LEN          = 11,
   parameter int SEL_POS          = 7,
   parameter bit RESTART_ON_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_i,
   input  logic               wr_i,
   input  logic [SEQ_LEN-1:0] hit_i,
   input  sel_e               sel_i,
   output logic               done_o,
   output sel_e               done_sel_o
);

   localparam int STEP_W = $clog2(SEQ_LEN);
   localparam int PAD_N  = 2 ** STEP_W;
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SEQ_LEN - 1);
   localparam logic [STEP_W-1:0] SEL_STEP_V = STEP_W'(SEL_POS);

   logic [STEP_W-1:0] step_q, step_d;
   sel_e              sel_q, sel_d;
   logic [PAD_N-1:0]  hit_pad;
   logic              cur_hit;
   logic              restart_one;

   always_comb begin
      hit_pad = '0;
      hit_pad[SEQ_LEN-1:0] = hit_i;
   end

   assign cur_hit = hit_pad[step_q];

   if (RESTART_ON_FIRST) begin : g_restart
      assign restart_one = hit_i[0];
   end else begin : g_norestart
      assign restart_one = 1'b0;
   end

   always_comb begin
      step_d = step_q;
      sel_d  = sel_q;
      if (rd_i) begin
         if (cur_hit) begin
            if (step_q == SEL_STEP_V) sel_d = sel_i;
            step_d = (step_q == LAST_STEP) ? '0 : step_q + STEP_W'(1);
         end else begin
            step_d = restart_one ? STEP_W'(1) : '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= '0;
         sel_q  <= SEL_NONE;
      end else begin
         step_q <= step_d;
         sel_q  <= sel_d;
      end
   end

   assign done_o     = rd_i && (step_q == LAST_STEP) && cur_hit;
   assign done_sel_o = sel_q;

   // R5: the step counter stays inside the chain
   a_r5_step_range: assert property (@(posedge clk) disable iff (!rst_n)
      step_q <= LAST_STEP);

   // R7: a write leaves the chain position untouched
   a_r7_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !rd_i) |=> $stable(step_q));

   // R8: an idle cycle leaves the chain position untouched
   a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_i && !rd_i) |=> $stable(step_q));

   // R6: a bad selector address drops the chain
   a_r6_bad_sel_aborts: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && step_q == SEL_STEP_V && sel_i == SEL_NONE) |=> (step_q <= STEP_W'(1)));

   // R4: completion only comes after a real selector was captured
   a_r4_done_has_sel: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (sel_q != SEL_NONE));

endmodule

// File: rtl/rdseq_mode_latch.sv
module rdseq_mode_latch
   import rdseq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic done_i,
   input  sel_e done_sel_i,
   output logic media_o,
   output logic wren_o
);

   logic media_q;
   logic wren_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         media_q <= 1'b0;
         wren_q  <= 1'b0;
      end else if (done_i) begin
         media_q <= (done_sel_i == SEL_MEDIA);
         wren_q  <= (done_sel_i == SEL_RAM);
      end
   end

   assign media_o = media_q;
   assign wren_o  = wren_q;

   // R2/R3: media mode and RAM writes are never on together
   a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(media_q && wren_q));

   // R4: outputs only move on a completed chain
   a_r4_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      !done_i |=> ($stable(media_q) && $stable(wren_q)));

   // R2: a media chain lands in media mode
   a_r2_media_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && done_sel_i == SEL_MEDIA) |=> (media_q && !wren_q));

   // R3: a RAM chain enables writes
   a_r3_ram_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && done_sel_i == SEL_RAM) |=> (!media_q && wren_q));

endmodule

// File: rtl/rdseq_unlock.sv
module rdseq_unlock
   import rdseq_pkg::*;
#(
   parameter int ADDR_W           = 32,
   parameter int SEQ_LEN          = 11,
   parameter int SEL_POS          = 7,
   parameter bit RESTART_ON_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic              mode_media,
   output logic              ram_wr_en
);

   if (ADDR_W < 28) begin : g_bad_addr_w
      $error("rdseq_unlock: ADDR_W must cover 28 address bits");
   end
   if (SEQ_LEN != CHAIN_LEN) begin : g_bad_len
      $error("rdseq_unlock: SEQ_LEN must equal the fixed chain length");
   end
   if (SEL_POS <= 0 || SEL_POS >= SEQ_LEN - 1) begin : g_bad_sel
      $error("rdseq_unlock: SEL_POS must sit strictly inside the chain");
   end

   logic               rd_acc;
   logic               wr_acc;
   logic [SEQ_LEN-1:0] hit;
   sel_e               sel_now;
   logic               chain_done;
   sel_e               chain_sel;

   assign rd_acc = acc_valid && !acc_write;
   assign wr_acc = acc_valid &&  acc_write;

   rdseq_match #(
      .ADDR_W  (ADDR_W),
      .SEQ_LEN (SEQ_LEN),
      .SEL_POS (SEL_POS)
   ) u_match (
      .addr_i (acc_addr),
      .hit_o  (hit),
      .sel_o  (sel_now)
   );

   rdseq_tracker #(
      .SEQ_LEN          (SEQ_LEN),
      .SEL_POS          (SEL_POS),
      .RESTART_ON_FIRST (RESTART_ON_FIRST)
   ) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_i       (rd_acc),
      .wr_i       (wr_acc),
      .hit_i      (hit),
      .sel_i      (sel_now),
      .done_o     (chain_done),
      .done_sel_o (chain_sel)
   );

   rdseq_mode_latch u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .done_i     (chain_done),
      .done_sel_i (chain_sel),
      .media_o    (mode_media),
      .wren_o     (ram_wr_en)
   );

   // R1: reset state is RAM mode with writes off
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_state: assert (!mode_media && !ram_wr_en);
      end
   end

endmodule

// File: tb/tb_rdseq_unlock.sv
module tb_rdseq_unlock;

   localparam logic [31:0] MED  = 32'h0880_0006;
   localparam logic [31:0] RAMC = 32'h0880_000C;
   localparam logic [31:0] BOGUS_SEL = 32'h0880_0008;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        mode_media;
   logic        ram_wr_en;

   int checks = 0;
   int errors = 0;
   bit done_flag = 1'b0;

   int m_step = 0;
   int m_sel  = 0;
   bit m_media = 1'b0;
   bit m_wren  = 1'b0;

   always #2.5 clk = ~clk;

   rdseq_unlock dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_valid  (acc_valid),
      .acc_write  (acc_write),
      .acc_addr   (acc_addr),
      .mode_media (mode_media),
      .ram_wr_en  (ram_wr_en)
   );

   function automatic logic [31:0] want_addr(input int i);
      case (i)
         0: return 32'h08E0_0002;
         1: return 32'h0800_000E;
         2: return 32'h0880_1FFC;
         3: return 32'h0800_104A;
         4: return 32'h0880_0612;
         5: return 32'h0800_0000;
         6: return 32'h0880_1B66;
         7: return MED;
         8: return 32'h0800_080E;
         9: return 32'h0800_0000;
         default: return 32'h0900_0000;
      endcase
   endfunction

   task automatic model(input bit w, input logic [31:0] a);
      bit hit;
      if (!w) begin
         if (m_step == 7) hit = (a == MED) || (a == RAMC);
         else             hit = (a == want_addr(m_step));
         if (hit) begin
            if (m_step == 7) m_sel = (a == MED) ? 1 : 2;
            if (m_step == 10) begin
               m_media = (m_sel == 1);
               m_wren  = (m_sel == 2);
               m_step  = 0;
            end else begin
               m_step++;
            end
         end else begin
            m_step = (a == want_addr(0)) ? 1 : 0;
         end
      end
   endtask

   task automatic check(input string tag);
      checks++;
      if (mode_media !== m_media || ram_wr_en !== m_wren) begin
         errors++;
         $display("FAIL %s: media=%0b wren=%0b expected media=%0b wren=%0b",
                  tag, mode_media, ram_wr_en, m_media, m_wren);
      end
   endtask

   task automatic acc(input bit w, input logic [31:0] a, input string tag);
      @(negedge clk);
      acc_valid = 1'b1;
      acc_write = w;
      acc_addr  = a;
      @(negedge clk);
      acc_valid = 1'b0;
      acc_write = 1'b0;
      acc_addr  = $urandom;
      model(w, a);
      check(tag);
   endtask

   task automatic run_chain(input logic [31:0] code, input int from, input int upto,
                            input string mid_tag, input string end_tag);
      for (int i = from; i <= upto; i++) begin
         acc(1'b0, (i == 7) ? code : want_addr(i), (i == 10) ? end_tag : mid_tag);
      end
   endtask

   initial begin
      #(5.0 * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      if (!done_flag) begin
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240607));
      repeat (3) @(negedge clk);
      checks++;  // R1 during reset
      if (mode_media !== 1'b0 || ram_wr_en !== 1'b0) begin
         errors++;
         $display("FAIL R1: media=%0b wren=%0b expected media=0 wren=0", mode_media, ram_wr_en);
      end
      rst_n = 1'b1;
      @(negedge clk);
      check("R1");

      // R4 then R2: media chain, outputs frozen until the last read
      run_chain(MED, 0, 10, "R4", "R2");
      // R3: RAM chain
      run_chain(RAMC, 0, 10, "R4", "R3");
      // R9: switch back and again
      run_chain(MED, 0, 10, "R9", "R9");
      run_chain(RAMC, 0, 10, "R9", "R9");

      // R5: wrong read in the middle resets, tail alone must not complete
      run_chain(MED, 0, 4, "R5", "R5");
      acc(1'b0, 32'h0800_1234, "R5");
      run_chain(MED, 5, 10, "R5", "R5");
      // R5: a mismatch on the opening address restarts at step one
      run_chain(MED, 0, 2, "R5", "R5");
      acc(1'b0, want_addr(0), "R5");
      run_chain(MED, 1, 10, "R5", "R5");

      // R6: a bad selector aborts
      run_chain(RAMC, 0, 6, "R6", "R6");
      acc(1'b0, BOGUS_SEL, "R6");
      run_chain(RAMC, 8, 10, "R6", "R6");

      // R7: writes interleaved, including to the opening address
      for (int i = 0; i <= 10; i++) begin
         acc(1'b1, want_addr(0), "R7");
         acc(1'b1, 32'h0BAD_0000 + 32'(i), "R7");
         acc(1'b0, (i == 7) ? RAMC : want_addr(i), "R7");
      end

      // R8: idle gaps between reads
      for (int i = 0; i <= 10; i++) begin
         repeat ($urandom_range(0, 3)) begin
            @(negedge clk);
            acc_addr = $urandom;
         end
         acc(1'b0, (i == 7) ? MED : want_addr(i), "R8");
      end

      // R9: constrained random mix
      for (int n = 0; n < 1500; n++) begin
         int pick;
         int st;
         logic [31:0] a;
         pick = $urandom_range(0, 99);
         st = m_step;
         if (pick < 65) begin
            if (st == 7) begin
               int c;
               c = $urandom_range(0, 9);
               a = (c < 5) ? MED : ((c < 9) ? RAMC : BOGUS_SEL);
            end else begin
               a = want_addr(st);
            end
            acc(1'b0, a, "R9");
         end else if (pick < 78) begin
            acc(1'b1, ($urandom_range(0, 1) == 1) ? want_addr(st) : $urandom, "R7");
         end else if (pick < 90) begin
            acc(1'b0, {4'h0, 28'($urandom)}, "R5");
         end else begin
            acc(1'b0, want_addr(0), "R5");
         end
      end

      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule